// File: doc/BRIEF.md
# Event-Flag Wake Controller

This block governs the execution state of a small stream processor core. It holds a bank of sticky event flags. Four kinds of agent can raise them: a host, a supervisor, a cluster synchronization unit and the core itself. The core writes a mask and a test mode, then asks to sleep. While it sleeps, the controller evaluates the masked flags every cycle. In any-of mode, one masked flag is enough. In all-of mode, every masked flag must be set. When the test is met, the controller returns the core to run. No interrupt mechanism exists. The flags are never consumed by a wake and stay set until the core clears them explicitly.

The controller has three states. RUN means the core executes freely. SLEEP means the core is halted. STEP means the core executes for exactly one cycle. The transitions are:
- RUN→SLEEP (go-to-sleep): on a sleep request when the test is false.
- RUN→RUN (sleep-refused): on a sleep request when the test is already true.
- SLEEP→RUN (wake): when the test is true.
- SLEEP→STEP (step-grant): on a step request when the test is false.
- STEP→SLEEP (step-done): after the single cycle, when the test is false.
- STEP→RUN (step-wake): after the single cycle, when the test is true.

Flag bit layout, from bit 0 upward:
- 4 host group flags.
- 4 supervisor device flags.
- 4 cluster flags.
- 16 core user flags.

The cluster flags form the region shared with the other cores of a cluster. The synchronization unit and the core may both set them.

Top module: `event_wake_ctrl`

## Requirements
- R1: Flag sources map as follows. `host_set[i]` sets flag i (bits 3:0). `sup_set[i]` sets flag 4+i (bits 7:4). `sync_set[i]` sets flag 8+i (bits 11:8). `self_set[j]` sets flag 8+j (bits 27:8, covering the cluster and user flags). Each flag is visible on `flags_o` after the clock edge that samples its strobe.
- R2: A set flag stays set, through a wake as well, until a `clr_vec` bit for it is applied. A clear removes only the addressed bits.
- R3: When a set and a clear reach the same flag in one cycle, the flag ends up set.
- R4: With mode 0 (any-of), `wake_o` is 1 exactly when `flags_o & mask` is nonzero.
- R5: With mode 1 (all-of), `wake_o` is 1 exactly when the mask is nonzero and `flags_o & mask` equals the mask.
- R6: With a zero mask, `wake_o` stays 0 in both modes, whatever the flags hold.
- R7: In SLEEP, a true test moves the state to RUN on the next clock edge (wake).
- R8: In RUN, a sleep request with a false test moves the state to SLEEP in one cycle. With a true test, the state stays in RUN.
- R9: In SLEEP, a step request with a false test enters STEP for exactly one cycle, then the state returns to SLEEP.
- R10: After reset, the state is RUN, all flags are 0, the mask is 0 and the mode is any-of.
- R11: Exactly one of `run_o`, `sleep_o` and `step_o` is 1 in every cycle. Writes to the mask and mode take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_set | input | 4 | Host group flag set strobes |
| sup_set | input | 4 | Supervisor device flag set strobes |
| sync_set | input | 4 | Cluster sync unit set strobes for the cluster flags |
| self_set | input | 20 | Core set strobes for the cluster and user flags (flags 27:8) |
| clr_vec | input | 28 | Core clear strobes, one per flag |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 28 | New mask value |
| mode_we | input | 1 | Mode write enable |
| mode_and | input | 1 | New mode: 0 any-of, 1 all-of |
| sleep_req | input | 1 | Core request to sleep |
| step_req | input | 1 | Request for one step cycle while asleep |
| flags_o | output | 28 | Current latched flags |
| wake_o | output | 1 | Current result of the masked test |
| run_o | output | 1 | State is RUN |
| sleep_o | output | 1 | State is SLEEP |
| step_o | output | 1 | State is STEP |

## Verification
The two results arrive at different times:
- A strobe sampled at a clock edge shows on `flags_o` right after that edge. `wake_o` follows in the same cycle, because it is combinational on the flag and mask registers.
- The state output reacts one edge later: a flag strobe at edge k gives `run_o` after edge k+1.

The bench drives every stimulus just after a falling edge and samples just after the next falling edge. At that first sample it checks flags and the test result, and it also confirms that the state has not yet moved. After a second edge it checks the new state. The test logic is swept exhaustively over all 4-bit masks and flag patterns in both modes, and the expected values are computed arithmetically.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_STEP  = 2'd2
    } ewc_state_t;
endpackage

// File: rtl/ewc_flag_bank.sv
module ewc_flag_bank #(
    parameter int FW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] set_vec,
    input  logic [FW-1:0] clr_vec,
    output logic [FW-1:0] flags_q
);
    for (genvar i = 0; i < FW; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[i] <= 1'b0;
            else if (set_vec[i])
                flags_q[i] <= 1'b1;   // set dominates a same-cycle clear
            else if (clr_vec[i])
                flags_q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flags_q[i]);                          // R3
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr_vec[i]) |=> flags_q[i]);         // R2
        AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !flags_q[i]);        // R2
    end
endmodule

// File: rtl/ewc_wake_eval.sv
module ewc_wake_eval #(
    parameter int FW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] flags,
    input  logic [FW-1:0] mask,
    input  logic          mode_and,
    output logic          hit
);
    logic [FW-1:0] masked;
    logic          any_hit;
    logic          all_hit;

    always_comb begin
        masked  = flags & mask;
        any_hit = |masked;
        all_hit = (|mask) && (masked == mask);
        hit     = mode_and ? all_hit : any_hit;
    end

    AST_EMPTY_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !hit);                                  // R6
    AST_AND_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_and && hit) |-> ((flags & mask) != '0));           // R5
endmodule

// File: rtl/event_wake_ctrl.sv
module event_wake_ctrl
    import ewc_pkg::*;
#(
    parameter  int N_HOST = 4,
    parameter  int N_SUP  = 4,
    parameter  int N_CLU  = 4,
    parameter  int N_USR  = 16,
    localparam int FW     = N_HOST + N_SUP + N_CLU + N_USR,
    localparam int CORE_W = N_CLU + N_USR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_HOST-1:0] host_set,
    input  logic [N_SUP-1:0]  sup_set,
    input  logic [N_CLU-1:0]  sync_set,
    input  logic [CORE_W-1:0] self_set,
    input  logic [FW-1:0]     clr_vec,
    input  logic              mask_we,
    input  logic [FW-1:0]     mask_wdata,
    input  logic              mode_we,
    input  logic              mode_and,
    input  logic              sleep_req,
    input  logic              step_req,
    output logic [FW-1:0]     flags_o,
    output logic              wake_o,
    output logic              run_o,
    output logic              sleep_o,
    output logic              step_o
);
    localparam int CORE_LSB = N_HOST + N_SUP;

    logic [FW-1:0] set_vec;
    logic [FW-1:0] mask_q;
    logic          mode_q;
    logic          hit;
    ewc_state_t    state_q, state_d;

    // gather set strobes into the flag layout
    always_comb begin
        set_vec = '0;
        set_vec[0 +: N_HOST]        = host_set;
        set_vec[N_HOST +: N_SUP]    = sup_set;
        set_vec[CORE_LSB +: N_CLU]  = sync_set;
        set_vec[CORE_LSB +: CORE_W] = set_vec[CORE_LSB +: CORE_W] | self_set;
    end

    ewc_flag_bank #(.FW(FW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags_q (flags_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= 1'b0;
        end else begin
            if (mask_we) mask_q <= mask_wdata;
            if (mode_we) mode_q <= mode_and;
        end
    end

    ewc_wake_eval #(.FW(FW)) u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (flags_o),
        .mask     (mask_q),
        .mode_and (mode_q),
        .hit      (hit)
    );

    assign wake_o = hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (sleep_req && !hit) state_d = ST_SLEEP;
            ST_SLEEP: if (hit)               state_d = ST_RUN;
                      else if (step_req)     state_d = ST_STEP;
            ST_STEP:  state_d = hit ? ST_RUN : ST_SLEEP;
            default:  state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        run_o   = 1'b0;
        sleep_o = 1'b0;
        step_o  = 1'b0;
        unique case (state_q)
            ST_RUN:   run_o   = 1'b1;
            ST_SLEEP: sleep_o = 1'b1;
            ST_STEP:  step_o  = 1'b1;
            default:  run_o   = 1'b1;
        endcase
    end

    AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && wake_o) |=> run_o);                          // R7
    AST_SLEEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && sleep_req && !wake_o) |=> sleep_o);            // R8
    AST_SLEEP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && wake_o) |=> run_o);                            // R8
    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);                                     // R9
    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({run_o, sleep_o, step_o}));                      // R11
endmodule

// File: tb/event_wake_ctrl_test.sv
module event_wake_ctrl_test;
    localparam int FW = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    host_set = '0;
    logic [3:0]    sup_set = '0;
    logic [3:0]    sync_set = '0;
    logic [19:0]   self_set = '0;
    logic [FW-1:0] clr_vec = '0;
    logic          mask_we = 1'b0;
    logic [FW-1:0] mask_wdata = '0;
    logic          mode_we = 1'b0;
    logic          mode_and = 1'b0;
    logic          sleep_req = 1'b0;
    logic          step_req = 1'b0;
    logic [FW-1:0] flags_o;
    logic          wake_o, run_o, sleep_o, step_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    event_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_set(host_set), .sup_set(sup_set),
        .sync_set(sync_set), .self_set(self_set), .clr_vec(clr_vec),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mode_we(mode_we),
        .mode_and(mode_and), .sleep_req(sleep_req), .step_req(step_req),
        .flags_o(flags_o), .wake_o(wake_o), .run_o(run_o),
        .sleep_o(sleep_o), .step_o(step_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one edge, then release all strobes just after the falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        host_set = '0; sup_set = '0; sync_set = '0; self_set = '0;
        clr_vec = '0; mask_we = 1'b0; mode_we = 1'b0;
        sleep_req = 1'b0; step_req = 1'b0;
    endtask

    task automatic clear_all();
        clr_vec = '1;
        cyc();
    endtask

    task automatic set_cfg(input logic [FW-1:0] m, input logic md);
        mask_we = 1'b1; mask_wdata = m; mode_we = 1'b1; mode_and = md;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic exp_hit;
        @(negedge clk);
        cyc();
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 flags", 32'(flags_o), 0);
        chk("R10 run", {29'd0, run_o, sleep_o, step_o}, 32'b100);
        chk("R10 wake", 32'(wake_o), 0);

        // R1: every source bit lands on its flag position
        for (int i = 0; i < 4; i++) begin
            host_set = 4'(1 << i); cyc();
            chk("R1 host", 32'(flags_o), 32'(1) << i);
            clear_all();
            sup_set = 4'(1 << i); cyc();
            chk("R1 sup", 32'(flags_o), 32'(1) << (4 + i));
            clear_all();
            sync_set = 4'(1 << i); cyc();
            chk("R1 sync", 32'(flags_o), 32'(1) << (8 + i));
            clear_all();
        end
        for (int j = 0; j < 20; j++) begin
            self_set = 20'(1 << j); cyc();
            chk("R1 self", 32'(flags_o), 32'(1) << (8 + j));
            clear_all();
        end

        // R2: sticky and selective clear
        host_set = 4'hF; sup_set = 4'hA; cyc();
        cyc(); cyc();
        chk("R2 sticky", 32'(flags_o), 32'h0AF);
        clr_vec = 28'h005; cyc();
        chk("R2 selective clear", 32'(flags_o), 32'h0AA);
        // R3: set wins over clear in the same cycle
        clr_vec = '1; host_set = 4'h4; cyc();
        chk("R3 set wins", 32'(flags_o), 32'h004);
        clear_all();

        // R4 R5 R6: exhaustive sweep over host bits, both modes
        for (int md = 0; md < 2; md++) begin
            for (int m = 0; m < 16; m++) begin
                set_cfg(28'(m), md[0]);
                for (int f = 0; f < 16; f++) begin
                    clear_all();
                    host_set = 4'(f); cyc();
                    if (md == 0) exp_hit = ((f & m) != 0);
                    else         exp_hit = (m != 0) && ((f & m) == m);
                    if (m == 0)       chk("R6 empty mask", 32'(wake_o), 0);
                    else if (md == 0) chk("R4 any-of", 32'(wake_o), 32'(exp_hit));
                    else              chk("R5 all-of", 32'(wake_o), 32'(exp_hit));
                end
            end
        end
        clear_all();

        // R11: config write takes effect next cycle
        host_set = 4'h1; cyc();
        set_cfg(28'h001, 1'b0);
        chk("R11 mask live", 32'(wake_o), 1);
        clear_all();

        // R8: sleep with false test
        sleep_req = 1'b1; cyc();
        chk("R8 sleep entry", {29'd0, run_o, sleep_o, step_o}, 32'b010);
        // R9: single step
        step_req = 1'b1; cyc();
        chk("R9 step", {29'd0, run_o, sleep_o, step_o}, 32'b001);
        cyc();
        chk("R9 step return", {29'd0, run_o, sleep_o, step_o}, 32'b010);
        // R6 in sleep: empty mask with all flags never wakes
        set_cfg('0, 1'b1);
        host_set = '1; sup_set = '1; sync_set = '1; self_set = '1; cyc();
        cyc();
        chk("R6 no wake", {29'd0, run_o, sleep_o, step_o}, 32'b010);
        clear_all();
        set_cfg(28'h001, 1'b0);

        // R7: wake timing
        host_set = 4'h1; cyc();
        chk("R7 wake comb", 32'(wake_o), 1);
        chk("R7 not yet", {29'd0, run_o, sleep_o, step_o}, 32'b010);
        cyc();
        chk("R7 woke", {29'd0, run_o, sleep_o, step_o}, 32'b100);
        chk("R2 kept after wake", 32'(flags_o), 32'h001);
        // R8: sleep refused while test true
        sleep_req = 1'b1; cyc();
        chk("R8 refused", {29'd0, run_o, sleep_o, step_o}, 32'b100);
        clear_all();

        // R5: all-of wake needs host0 and cluster0
        set_cfg(28'h101, 1'b1);
        sleep_req = 1'b1; cyc();
        host_set = 4'h1; cyc(); cyc();
        chk("R5 partial", {29'd0, run_o, sleep_o, step_o}, 32'b010);
        sync_set = 4'h1; cyc(); cyc();
        chk("R5 full", {29'd0, run_o, sleep_o, step_o}, 32'b100);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule